// File: doc/BRIEF.md
# Endpoint BAR Size and Type Encoder

This block turns a base-address-register setup request for one endpoint function into the packed BAR configuration words that the controller decodes. A request names a BAR slot from 0 to 5. It also carries a byte size, an I/O-space flag and a prefetchable flag. The block rounds the size up to a power of two, with a floor of 128 bytes, and records it as a log2 offset. It picks the control type, deciding 32-bit or 64-bit decoding from the rounded size. It then rewrites only the 8-bit lane that belongs to that BAR.

A clear request sets one lane to the disabled type. It also sends a one-cycle strobe with the BAR index to the inbound translation store, which zeroes both 32-bit translation address words of that BAR. Illegal requests leave every lane untouched. Each request, legal or not, is answered by a one-cycle done pulse that carries an error bit. Software reads the lanes back from two 32-bit words.

Top module: `bar_cfg_encoder`

## Requirements
- R1: The aperture code in lane bits [4:0] equals ceil(log2(max(size,128))) − 7, so 0 to 128 bytes give 0, 129 to 256 bytes give 1, and 4096 bytes give 5.
- R2: A memory BAR is 64-bit exactly when its rounded size exceeds 2^31 bytes. The type code in lane bits [7:5] is 4 for 32-bit memory, 5 for 32-bit prefetchable, 6 for 64-bit memory and 7 for 64-bit prefetchable.
- R3: An I/O request always gets type code 1, whatever its size and prefetchable flag.
- R4: BARs 0 to 3 sit in word 0 at bits [8b+7:8b]. BAR 4 sits in word 1 bits [7:0] and BAR 5 in word 1 bits [15:8]. Bits [31:16] of word 1 read zero.
- R5: A successful set or clear changes only the lane of the addressed BAR.
- R6: A request whose result would be a 64-bit BAR on an odd index is answered with an error and changes no lane.
- R7: A set or clear on BAR index 6 or 7 is answered with an error and changes no lane.
- R8: A size whose rounded value exceeds 2^38 bytes (the 5-bit aperture limit), including any size above 2^63, is answered with an error and changes no lane.
- R9: A legal clear writes 0x00 into the lane (type 0 = disabled, aperture 0). In the done cycle it raises the translation-zero strobe for one cycle, with that BAR index. No other request raises the strobe.
- R10: After reset both words read zero and done is low. Each request accepted on a clock edge gives exactly one done pulse in the next cycle, with its error bit; done stays low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_clear | input | 1 | 1 = clear (disable) the BAR, 0 = set |
| req_bar | input | 3 | BAR index |
| req_size | input | 64 | Requested size in bytes |
| req_io | input | 1 | I/O space request |
| req_pf | input | 1 | Prefetchable memory request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected, valid with rsp_done |
| xlat_zero | output | 1 | Zero both translation words of xlat_bar |
| xlat_bar | output | 3 | BAR index for xlat_zero |
| cfg_word0 | output | 32 | Lanes of BARs 0 to 3 |
| cfg_word1 | output | 32 | Lanes of BARs 4 and 5 |

## Verification
All results appear one cycle after the edge that accepts a request: done, the error bit, the translation strobe and the new lane contents. The bench sets a request on a falling edge and queues the expected response at that moment. The monitor checks outputs only on the next falling edge, so the register between them is counted once. The monitor pops an item only when done is seen. A done with an empty queue, a strobe without done, or items still queued at the end all count as failures.

// File: rtl/bar_enc_pkg.sv
package bar_enc_pkg;
  parameter int NUM_BAR   = 6;
  parameter int LANE_W    = 8;
  parameter int AP_W      = 5;
  parameter int TYPE_W    = 3;
  parameter int SIZE_W    = 64;
  parameter int MIN_LOG2  = 7;
  parameter int WIDE_LOG2 = 31;
  parameter int WORD_W    = 32;
  localparam int LANES_PER_WORD = WORD_W / LANE_W;
  localparam int NUM_WORD = (NUM_BAR + LANES_PER_WORD - 1) / LANES_PER_WORD;
  localparam int IDX_W    = $clog2(NUM_BAR + 1);
  localparam int LG_W     = $clog2(SIZE_W + 1);
  localparam int MAX_LOG2 = MIN_LOG2 + (1 << AP_W) - 1;

  typedef enum logic [TYPE_W-1:0] {
    BT_OFF   = 3'd0,
    BT_IO32  = 3'd1,
    BT_MEM32 = 3'd4,
    BT_PF32  = 3'd5,
    BT_MEM64 = 3'd6,
    BT_PF64  = 3'd7
  } bar_type_e;
endpackage

// File: rtl/bar_ap_calc.sv
module bar_ap_calc
  import bar_enc_pkg::*;
(
  input  logic [SIZE_W-1:0] size_i,
  output logic [LG_W-1:0]   lg_o,
  output logic [AP_W-1:0]   ap_o,
  output logic              too_big_o
);
  localparam logic [SIZE_W-1:0] FLOOR = SIZE_W'(1) << MIN_LOG2;

  logic [SIZE_W-1:0] m;
  logic [LG_W-1:0]   top;

  always_comb begin
    m = (size_i <= FLOOR) ? (FLOOR - SIZE_W'(1)) : (size_i - SIZE_W'(1));
    top = '0;
    for (int i = 0; i < SIZE_W; i++) begin
      if (m[i]) top = LG_W'(i);
    end
    lg_o      = top + LG_W'(1);
    too_big_o = (int'(lg_o) > MAX_LOG2);
    ap_o      = AP_W'(lg_o - LG_W'(MIN_LOG2));
  end
endmodule

// File: rtl/bar_type_sel.sv
module bar_type_sel
  import bar_enc_pkg::*;
(
  input  logic            is_io_i,
  input  logic            pf_i,
  input  logic [LG_W-1:0] lg_i,
  output bar_type_e       type_o,
  output logic            wide_o
);
  always_comb begin
    wide_o = !is_io_i && (int'(lg_i) > WIDE_LOG2);
    if (is_io_i)     type_o = BT_IO32;
    else if (wide_o) type_o = pf_i ? BT_PF64 : BT_MEM64;
    else             type_o = pf_i ? BT_PF32 : BT_MEM32;
  end
endmodule

// File: rtl/bar_lane_store.sv
module bar_lane_store
  import bar_enc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [LANE_W-1:0]          wr_lane,
  output logic [NUM_WORD*WORD_W-1:0] packed_o
);
  logic [LANE_W-1:0] lane_q [NUM_BAR];

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g))) lane_q[g] <= wr_lane;
    end
  end

  always_comb begin
    packed_o = '0;
    for (int i = 0; i < NUM_BAR; i++) packed_o[i*LANE_W +: LANE_W] = lane_q[i];
  end
endmodule

// File: rtl/bar_cfg_encoder.sv
module bar_cfg_encoder
  import bar_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_clear,
  input  logic [2:0]  req_bar,
  input  logic [63:0] req_size,
  input  logic        req_io,
  input  logic        req_pf,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic        xlat_zero,
  output logic [2:0]  xlat_bar,
  output logic [31:0] cfg_word0,
  output logic [31:0] cfg_word1
);
  logic [LG_W-1:0]            lg;
  logic [AP_W-1:0]            ap;
  logic                       too_big;
  bar_type_e                  btype;
  logic                       wide;
  logic                       bad_idx;
  logic                       err_c;
  logic                       wr_en;
  logic [LANE_W-1:0]          new_lane;
  logic [NUM_WORD*WORD_W-1:0] packed_w;

  bar_ap_calc u_ap (
    .size_i   (req_size),
    .lg_o     (lg),
    .ap_o     (ap),
    .too_big_o(too_big)
  );

  bar_type_sel u_type (
    .is_io_i(req_io),
    .pf_i   (req_pf),
    .lg_i   (lg),
    .type_o (btype),
    .wide_o (wide)
  );

  always_comb begin
    bad_idx = (int'(req_bar) >= NUM_BAR);
    if (req_clear) begin
      err_c    = bad_idx;
      new_lane = {BT_OFF, {AP_W{1'b0}}};
    end else begin
      err_c    = bad_idx || too_big || (wide && req_bar[0]);
      new_lane = {btype, ap};
    end
    wr_en = req_valid && !err_c;
  end

  bar_lane_store u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (IDX_W'(req_bar)),
    .wr_lane (new_lane),
    .packed_o(packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      xlat_zero <= 1'b0;
      xlat_bar  <= '0;
    end else begin
      rsp_done  <= req_valid;
      rsp_err   <= req_valid && err_c;
      xlat_zero <= req_valid && req_clear && !err_c;
      xlat_bar  <= req_bar;
    end
  end

  assign cfg_word0 = packed_w[31:0];
  assign cfg_word1 = packed_w[63:32];

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done); // R10
  AST_ERR_KEEPS_LANES: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> ($stable(cfg_word0) && $stable(cfg_word1))); // R6
  AST_XLAT_ONLY_OK_DONE: assert property (@(posedge clk) disable iff (rst)
    xlat_zero |-> (rsp_done && !rsp_err)); // R9
  AST_WIDE_NEEDS_BIG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !req_clear && (btype == BT_MEM64 || btype == BT_PF64))
      |-> (int'(ap) > WIDE_LOG2 - MIN_LOG2)); // R2
  AST_BAD_IDX_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_idx) |=> rsp_err); // R7
endmodule

// File: tb/sim_bar_cfg_encoder.sv
module sim_bar_cfg_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_clear = 1'b0, req_io = 1'b0, req_pf = 1'b0;
  logic [2:0]  req_bar = '0;
  logic [63:0] req_size = '0;
  logic        rsp_done, rsp_err, xlat_zero;
  logic [2:0]  xlat_bar;
  logic [31:0] cfg_word0, cfg_word1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit        err;
    bit        xz;
    bit [2:0]  xb;
    bit [63:0] w;
    string     tag;
  } item_t;
  item_t q[$];
  bit [63:0] shadow = '0;

  always #10 clk = ~clk;

  bar_cfg_encoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_clear(req_clear),
    .req_bar(req_bar), .req_size(req_size), .req_io(req_io), .req_pf(req_pf),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .xlat_zero(xlat_zero),
    .xlat_bar(xlat_bar), .cfg_word0(cfg_word0), .cfg_word1(cfg_word1)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit clr, input int bar, input logic [63:0] size,
                        input bit io, input bit pf, input string tag);
    item_t it;
    bit e;
    bit [7:0] lane;
    bit [63:0] r;
    int l;
    bit wide;
    bit [2:0] ty;
    e = (bar > 5);
    lane = 8'h00;
    if (!clr) begin
      if (size > (64'd1 << 38)) e = 1;
      else begin
        r = 64'd128; l = 7;
        while (r < size) begin r = r << 1; l++; end
        wide = !io && (l > 31);
        if (wide && bar[0]) e = 1;
        ty = io ? 3'd1 : wide ? (pf ? 3'd7 : 3'd6) : (pf ? 3'd5 : 3'd4);
        lane = {ty, 5'(l - 7)};
      end
    end
    if (!e) shadow[bar*8 +: 8] = lane;
    it.err = e; it.xz = clr && !e; it.xb = 3'(bar); it.w = shadow; it.tag = tag;
    @(negedge clk);
    req_valid = 1; req_clear = clr; req_bar = 3'(bar); req_size = size;
    req_io = io; req_pf = pf;
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_done) begin
        if (q.size() == 0) chk(0, "R10 done without request", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(rsp_err == it.err, {it.tag, " err"}, 64'(rsp_err), 64'(it.err));
          chk({cfg_word1, cfg_word0} == it.w, {it.tag, " words"}, {cfg_word1, cfg_word0}, it.w);
          chk(xlat_zero == it.xz, {it.tag, " R9 strobe"}, 64'(xlat_zero), 64'(it.xz));
          if (it.xz) chk(xlat_bar == it.xb, {it.tag, " R9 bar"}, 64'(xlat_bar), 64'(it.xb));
        end
      end else if (xlat_zero) chk(0, "R9 strobe without done", 1, 0);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=hang exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cfg_word0 == 0 && cfg_word1 == 0, "R10 reset words", {cfg_word1, cfg_word0}, 0);
    chk(rsp_done == 0, "R10 reset done", 64'(rsp_done), 0);
    do_req(0, 0, 64'd0,    0, 0, "R1 zero size");
    do_req(0, 0, 64'd128,  0, 0, "R1 exact floor");
    do_req(0, 0, 64'd129,  0, 0, "R1 round 129");
    do_req(0, 0, 64'd4096, 0, 0, "R1 R4 bar0 4K");
    do_req(0, 1, 64'd1000000, 0, 1, "R2 R5 bar1 pf32");
    do_req(0, 2, 64'd1 << 33, 1, 1, "R3 io large");
    do_req(0, 3, 64'd1 << 31, 0, 1, "R2 2GiB stays 32");
    do_req(0, 4, 64'd1 << 32, 0, 0, "R2 R4 bar4 mem64");
    do_req(0, 0, (64'd1 << 31) + 1, 0, 1, "R2 pf64 bar0");
    do_req(0, 5, 64'd1 << 32, 0, 0, "R6 odd 64-bit");
    do_req(0, 5, 64'd300, 0, 0, "R4 R5 bar5 lane");
    do_req(0, 6, 64'd256, 0, 0, "R7 set idx6");
    do_req(0, 4, 64'd1 << 38, 0, 1, "R8 max size ok");
    do_req(0, 4, (64'd1 << 38) + 1, 0, 0, "R8 over limit");
    do_req(0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R8 above 2^63");
    do_req(1, 1, 64'd0, 0, 0, "R9 R5 clear bar1");
    do_req(1, 7, 64'd0, 0, 0, "R7 clear idx7");
    do_req(1, 4, 64'd0, 0, 0, "R9 clear bar4");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10 missing done", 64'(q.size()), 0);
    chk(cfg_word1[31:16] == 0, "R4 upper zero", 64'(cfg_word1), 0);
    summary();
  end
endmodule